// File: doc/BRIEF.md
# Processor Status Register Unit

An eight-bit status register for a small eight-bit processor core. It keeps the global interrupt enable (I), a single bit-copy cell (T), and the arithmetic flags H, S, V, N, Z and C. The ALU proposes new flag values together with a per-flag write mask, so an instruction changes only the flags it owns. The sign flag is never stored as given: it is always rebuilt from N and V.

The unit also carries out the two bit-transfer operations of the core. A bit-store copies one chosen bit of a register-file byte into T. A bit-load returns that register-file byte with the chosen bit replaced by T, for the core to write back. The interrupt logic drops I when an interrupt is accepted and raises it again on return-from-interrupt. Software can write the whole byte at once, and the present value is always visible on the output. Nothing is pushed or restored on interrupt entry or exit: that stays with software.

Top module: `psr_unit`

## Requirements
- R1: After reset `status` reads 8'h00; the bit layout is 7=I, 6=T, 5=H, 4=S, 3=V, 2=N, 1=Z, 0=C.
- R2: At every clock edge outside reset, `status[4]` equals `status[2]` XOR `status[3]`, whatever value was written.
- R3: With `sw_we` low, each set bit of `alu_mask` loads the same bit of `alu_flags` into its flag on the next edge, using the encoding bit 4=H, 3=V, 2=N, 1=Z, 0=C; flags whose mask bit is clear keep their value.
- R4: With `bst_en` high and `sw_we` low, T takes `rf_byte[bit_sel]` on the next edge and no other bit is changed by the bit-store.
- R5: `bld_byte` is, in the same cycle, `rf_byte` with bit `bit_sel` replaced by the present T and the other seven bits passed through.
- R6: A cycle with `irq_ack` high leaves I cleared after the next edge.
- R7: A cycle with `reti` high and `irq_ack` low leaves I set; with both high, I ends cleared.
- R8: With `sw_we` high, bits 6, 5, 3, 2, 1, 0 take `sw_wdata` on the next edge, overriding ALU updates and bit-store in that cycle; S is recomputed from the written N and V; bit 7 takes `sw_wdata[7]` unless `irq_ack` or `reti` is high.
- R9: Interrupt acceptance and return change only I; bits 6 to 0 are neither saved nor restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_mask | input | 5 | Per-flag write enable {H,V,N,Z,C} |
| alu_flags | input | 5 | Proposed flag values {H,V,N,Z,C} |
| sw_we | input | 1 | Whole-byte software write strobe |
| sw_wdata | input | 8 | Byte for the software write |
| bst_en | input | 1 | Bit-store: copy selected register bit into T |
| rf_byte | input | 8 | Register-file byte for bit-store and bit-load |
| bit_sel | input | 3 | Selected bit position 0 to 7 |
| irq_ack | input | 1 | Interrupt accepted this cycle |
| reti | input | 1 | Return-from-interrupt this cycle |
| status | output | 8 | Present register value |
| bld_byte | output | 8 | Bit-load result: rf_byte with T inserted |

## Verification
The hardest situation to reach is a single cycle in which several sources compete for the same bits: a software write arriving together with an ALU update, a bit-store and an interrupt acceptance or return. The stimulus table steps through such collision cycles deliberately, including a write whose S bit contradicts its N and V, and an acceptance coinciding with a return while I is set, with each expected byte worked out by hand from the priority rules. Directed passes then sweep the bit-load over all eight positions with T at both values and reset the unit mid-run.

// File: rtl/psr_pkg.sv
package psr_pkg;
   localparam int SR_W   = 8;
   localparam int FLAG_W = 5;
   // bit positions inside the status byte
   localparam int POS_I = 7;
   localparam int POS_T = 6;
   localparam int POS_H = 5;
   localparam int POS_S = 4;
   localparam int POS_V = 3;
   localparam int POS_N = 2;
   localparam int POS_Z = 1;
   localparam int POS_C = 0;
endpackage

// File: rtl/psr_flag_merge.sv
// Merges ALU flag proposals into the stored flags under a write mask.
module psr_flag_merge #(
   parameter int FLAG_W = psr_pkg::FLAG_W
) (
   input  logic [FLAG_W-1:0] cur_flags,
   input  logic [FLAG_W-1:0] wr_mask,
   input  logic [FLAG_W-1:0] new_flags,
   output logic [FLAG_W-1:0] nxt_flags
);
   for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
      assign nxt_flags[g] = wr_mask[g] ? new_flags[g] : cur_flags[g];
   end
endmodule

// File: rtl/psr_bit_xfer.sv
// Bit extraction for bit-store and bit insertion for bit-load.
module psr_bit_xfer #(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src_byte,
   input  logic [IDX_W-1:0]  sel,
   input  logic              t_cur,
   output logic              t_pick,
   output logic [DATA_W-1:0] ins_byte
);
   assign t_pick = src_byte[sel];
   for (genvar g = 0; g < DATA_W; g++) begin : g_ins
      assign ins_byte[g] = (sel == IDX_W'(g)) ? t_cur : src_byte[g];
   end
endmodule

// File: rtl/psr_ie_ctrl.sv
// Next value of the global interrupt enable.
module psr_ie_ctrl #(
   parameter bit ACK_FIRST = 1'b1
) (
   input  logic ie_cur,
   input  logic sw_we,
   input  logic sw_ie,
   input  logic irq_ack,
   input  logic reti,
   output logic ie_nxt
);
   logic ie_base;
   assign ie_base = sw_we ? sw_ie : ie_cur;

   if (ACK_FIRST) begin : g_ack_first
      assign ie_nxt = irq_ack ? 1'b0 : (reti ? 1'b1 : ie_base);
   end else begin : g_reti_first
      assign ie_nxt = reti ? 1'b1 : (irq_ack ? 1'b0 : ie_base);
   end
endmodule

// File: rtl/psr_unit.sv
module psr_unit #(
   parameter int          DATA_W    = psr_pkg::SR_W,
   parameter int          FLAG_W    = psr_pkg::FLAG_W,
   parameter bit          ACK_FIRST = 1'b1,
   parameter logic [7:0]  RST_VAL   = 8'h00,
   localparam int         IDX_W     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] alu_mask,
   input  logic [FLAG_W-1:0] alu_flags,
   input  logic              sw_we,
   input  logic [DATA_W-1:0] sw_wdata,
   input  logic              bst_en,
   input  logic [DATA_W-1:0] rf_byte,
   input  logic [IDX_W-1:0]  bit_sel,
   input  logic              irq_ack,
   input  logic              reti,
   output logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] bld_byte
);
   import psr_pkg::*;

   if (DATA_W != 8) begin : g_bad_width
      $error("psr_unit: DATA_W must be 8");
   end
   if (FLAG_W != 5) begin : g_bad_flags
      $error("psr_unit: FLAG_W must be 5");
   end
   if (RST_VAL[POS_S] != (RST_VAL[POS_N] ^ RST_VAL[POS_V])) begin : g_bad_rst
      $error("psr_unit: RST_VAL sign bit inconsistent with N and V");
   end

   logic [DATA_W-1:0] sr_q;
   logic [DATA_W-1:0] base;
   logic [DATA_W-1:0] sr_d;
   logic [FLAG_W-1:0] cur_flags;
   logic [FLAG_W-1:0] alu_nxt;
   logic              t_pick;
   logic              t_nxt;
   logic              ie_nxt;

   assign cur_flags = {sr_q[POS_H], sr_q[POS_V], sr_q[POS_N], sr_q[POS_Z], sr_q[POS_C]};

   psr_flag_merge #(.FLAG_W(FLAG_W)) u_merge (
      .cur_flags (cur_flags),
      .wr_mask   (alu_mask),
      .new_flags (alu_flags),
      .nxt_flags (alu_nxt)
   );

   psr_bit_xfer #(.DATA_W(DATA_W)) u_xfer (
      .src_byte (rf_byte),
      .sel      (bit_sel),
      .t_cur    (sr_q[POS_T]),
      .t_pick   (t_pick),
      .ins_byte (bld_byte)
   );

   psr_ie_ctrl #(.ACK_FIRST(ACK_FIRST)) u_ie (
      .ie_cur  (sr_q[POS_I]),
      .sw_we   (sw_we),
      .sw_ie   (sw_wdata[POS_I]),
      .irq_ack (irq_ack),
      .reti    (reti),
      .ie_nxt  (ie_nxt)
   );

   assign t_nxt = bst_en ? t_pick : sr_q[POS_T];

   // software write wins over ALU and bit-store for bits 6..0
   always_comb begin
      if (sw_we) begin
         base = sw_wdata;
      end else begin
         base          = sr_q;
         base[POS_T]   = t_nxt;
         base[POS_H]   = alu_nxt[4];
         base[POS_V]   = alu_nxt[3];
         base[POS_N]   = alu_nxt[2];
         base[POS_Z]   = alu_nxt[1];
         base[POS_C]   = alu_nxt[0];
      end
   end

   always_comb begin
      sr_d        = base;
      sr_d[POS_S] = sr_d[POS_N] ^ sr_d[POS_V];
      sr_d[POS_I] = ie_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= RST_VAL;
      else        sr_q <= sr_d;
   end

   assign status = sr_q;
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [4:0] alu_mask,
   input logic [4:0] alu_flags,
   input logic       sw_we,
   input logic [7:0] sw_wdata,
   input logic       bst_en,
   input logic [7:0] rf_byte,
   input logic [2:0] bit_sel,
   input logic       irq_ack,
   input logic       reti,
   input logic [7:0] status,
   input logic [7:0] bld_byte
);
   p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
      status[4] == (status[2] ^ status[3]));

   p_alu_h_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_we && alu_mask[4]) |=> status[5] == $past(alu_flags[4]));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_we && !bst_en && !irq_ack && !reti && alu_mask == 5'd0) |=> $stable(status));

   p_bst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bst_en && !sw_we) |=> status[6] == $past(rf_byte[bit_sel]));

   p_bld_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bld_byte[bit_sel] == status[6]);

   p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !status[7]);

   p_reti_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !irq_ack) |=> status[7]);

   p_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we |=> (status[6:5] == $past(sw_wdata[6:5]) && status[3:0] == $past(sw_wdata[3:0])));

   p_irq_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_ack || reti) && !sw_we && !bst_en && alu_mask == 5'd0) |=> $stable(status[6:0]));
endmodule

bind psr_unit psr_unit_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .alu_mask  (alu_mask),
   .alu_flags (alu_flags),
   .sw_we     (sw_we),
   .sw_wdata  (sw_wdata),
   .bst_en    (bst_en),
   .rf_byte   (rf_byte),
   .bit_sel   (bit_sel),
   .irq_ack   (irq_ack),
   .reti      (reti),
   .status    (status),
   .bld_byte  (bld_byte)
);

// File: tb/psr_unit_tb_top.sv
`timescale 1ns/1ps
module psr_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] alu_mask = '0;
   logic [4:0] alu_flags = '0;
   logic       sw_we = 1'b0;
   logic [7:0] sw_wdata = '0;
   logic       bst_en = 1'b0;
   logic [7:0] rf_byte = '0;
   logic [2:0] bit_sel = '0;
   logic       irq_ack = 1'b0;
   logic       reti = 1'b0;
   logic [7:0] status;
   logic [7:0] bld_byte;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   psr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .alu_mask(alu_mask), .alu_flags(alu_flags),
      .sw_we(sw_we), .sw_wdata(sw_wdata), .bst_en(bst_en), .rf_byte(rf_byte),
      .bit_sel(bit_sel), .irq_ack(irq_ack), .reti(reti),
      .status(status), .bld_byte(bld_byte)
   );

   typedef struct packed {
      logic [4:0] mask;
      logic [4:0] flg;
      logic       sw;
      logic [7:0] wd;
      logic       bst;
      logic [7:0] rf;
      logic [2:0] sel;
      logic       ack;
      logic       rti;
      logic [7:0] exp;
   } vec_t;

   localparam int NV = 16;
   // mask/flags encoding {H,V,N,Z,C}; status layout I T H S V N Z C
   localparam vec_t VEC [NV] = '{
      '{5'b00000, 5'b00000, 1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 1'b1, 8'h80}, // R7 reti sets I
      '{5'b11111, 5'b00100, 1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h94}, // R3 N=1, R2 S=1
      '{5'b01000, 5'b01000, 1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h8C}, // R3 V only, R2 S=0
      '{5'b00000, 5'b11111, 1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h8C}, // R3 unmasked hold
      '{5'b00011, 5'b00011, 1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h8F}, // R3 Z,C
      '{5'b00000, 5'b00000, 1'b0, 8'h00, 1'b1, 8'h20, 3'd5, 1'b0, 1'b0, 8'hCF}, // R4 T<=1
      '{5'b00000, 5'b00000, 1'b0, 8'h00, 1'b1, 8'hDF, 3'd5, 1'b0, 1'b0, 8'h8F}, // R4 T<=0
      '{5'b00000, 5'b00000, 1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b1, 1'b0, 8'h0F}, // R6 R9
      '{5'b00000, 5'b00000, 1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 1'b1, 8'h8F}, // R7 R9
      '{5'b00000, 5'b00000, 1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b1, 1'b1, 8'h0F}, // R7 both
      '{5'b11111, 5'b00000, 1'b1, 8'h7F, 1'b1, 8'h00, 3'd6, 1'b0, 1'b0, 8'h6F}, // R8 wins, S fixed
      '{5'b00000, 5'b00000, 1'b1, 8'h80, 1'b0, 8'h00, 3'd0, 1'b1, 1'b0, 8'h00}, // R8 ack beats write
      '{5'b00000, 5'b00000, 1'b1, 8'h84, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h94}, // R8 S derived
      '{5'b10000, 5'b10000, 1'b0, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'hB4}, // R3 H
      '{5'b00000, 5'b00000, 1'b0, 8'h00, 1'b1, 8'h01, 3'd0, 1'b0, 1'b0, 8'hF4}, // R4 sel 0
      '{5'b00000, 5'b00000, 1'b1, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 1'b1, 8'h80}  // R8 reti beats write
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ins_bit(input logic [7:0] b, input logic [2:0] s, input logic t);
      logic [7:0] r;
      r = b;
      r[s] = t;
      return r;
   endfunction

   task automatic idle();
      alu_mask = '0; alu_flags = '0; sw_we = 1'b0; sw_wdata = '0;
      bst_en = 1'b0; rf_byte = '0; bit_sel = '0; irq_ack = 1'b0; reti = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] model;
      idle();
      repeat (3) @(negedge clk);
      chk("R1 reset value", status, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 hold after reset", status, 8'h00);

      model = 8'h00;
      for (int i = 0; i < NV; i++) begin
         alu_mask = VEC[i].mask; alu_flags = VEC[i].flg;
         sw_we = VEC[i].sw; sw_wdata = VEC[i].wd;
         bst_en = VEC[i].bst; rf_byte = VEC[i].rf; bit_sel = VEC[i].sel;
         irq_ack = VEC[i].ack; reti = VEC[i].rti;
         #1;
         chk("R5 bld in table", bld_byte, ins_bit(VEC[i].rf, VEC[i].sel, model[6]));
         @(negedge clk);
         chk("table R2 R3 R4 R6 R7 R8 R9", status, VEC[i].exp);
         chk("R2 sign bit", {7'd0, status[4]}, {7'd0, status[2] ^ status[3]});
         model = VEC[i].exp;
      end

      // R5: sweep every position with T=1 then T=0
      idle();
      sw_we = 1'b1; sw_wdata = 8'h40;
      @(negedge clk);
      idle();
      chk("R8 write T", status, 8'h40);
      for (int s = 0; s < 8; s++) begin
         rf_byte = 8'h00; bit_sel = 3'(s);
         #1;
         chk("R5 insert T=1", bld_byte, 8'(1 << s));
         @(negedge clk);
      end
      chk("R5 no state change", status, 8'h40);
      sw_we = 1'b1; sw_wdata = 8'h00;
      @(negedge clk);
      idle();
      for (int s = 0; s < 8; s++) begin
         rf_byte = 8'hFF; bit_sel = 3'(s);
         #1;
         chk("R5 insert T=0", bld_byte, ~8'(1 << s));
         @(negedge clk);
      end

      // R2: write contradicting S, N=1 V=0 -> S=1
      sw_we = 1'b1; sw_wdata = 8'h04;
      @(negedge clk);
      idle();
      chk("R2 write S=0 with N=1", status, 8'h14);

      // R1: reset in mid-run
      sw_we = 1'b1; sw_wdata = 8'hFF;
      @(negedge clk);
      idle();
      chk("R8 write all ones, S forced 0", status, 8'hEF);
      rst_n = 1'b0;
      #1;
      chk("R1 asynchronous reset", status, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after second reset", status, 8'h00);

      finish_run();
   end
endmodule